// File: doc/BRIEF.md
# Four-Channel Mixed-Priority DMA Request Arbiter

This block picks one winner among four DMA channel requests each time an arbitration strobe arrives. A 2-bit mode input selects the scheme. All four channels can rotate in round robin. All four can be ranked strictly by index. In the two hybrid schemes, the lowest one or two channels hold fixed precedence, and the remaining channels rotate in a round-robin group below them.

The winner is registered on the strobe. It is presented as a one-hot grant with a separate valid flag, and it stays unchanged until the next strobe. The round-robin pointer moves only when a member of the rotating group wins. A change of scheme makes the rotation start again from the lowest channel of the new group. The surrounding transfer engine samples the grant after each strobe.

Top module: `dma_mix_arbiter`

## Requirements
- R1: With mode 2'b00, all four channels rotate in round robin. Under a constant request from every channel, successive strobes grant channel 0, 1, 2, 3, 0 in turn (bit i of `reqVec` and `grantOh` is channel i).
- R2: With mode 2'b01, a requesting channel 0 always wins. Otherwise channels 1, 2 and 3 rotate in round robin.
- R3: With mode 2'b10, channel 0 wins over channel 1, and channel 1 wins over channels 2 and 3. Channels 2 and 3 rotate in round robin when neither 0 nor 1 requests.
- R4: With mode 2'b11, the lowest-numbered requesting channel wins: channel 0 is highest and channel 3 is lowest.
- R5: After reset, `grantOh` is 4'b0000 and `grantValid` is 0. The remembered mode is 2'b00 and the rotation pointer is at channel 0, so the first strobe in mode 2'b00 with every channel requesting grants channel 0.
- R6: The rotation pointer changes only when a channel of the round-robin group wins. It then moves to the next channel of that group after the winner, wrapping to the lowest channel of the group. A fixed-priority win leaves the pointer where it was.
- R7: A strobe with `reqVec` all zero gives `grantOh` 4'b0000 and `grantValid` 0, and it leaves the rotation pointer unchanged.
- R8: The grant is evaluated only in a cycle with `arbStrobe` high. It appears after that clock edge and holds unchanged while the strobe is low, whatever `reqVec` and `modeSel` do.
- R9: When `modeSel` at a strobe differs from the mode of the previous strobe, the round-robin search for that strobe starts at the lowest channel of the new group.
- R10: `grantOh` is always one-hot or zero. `grantValid` is 1 exactly when it is nonzero, and a granted channel was requesting at the evaluating strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | 4 | Channel requests, bit i = channel i |
| modeSel | input | 2 | Arbitration scheme select |
| arbStrobe | input | 1 | Evaluate a new grant this cycle |
| grantOh | output | 4 | Registered one-hot grant |
| grantValid | output | 1 | A channel is granted |

## Verification
The hardest case to reach is a scheme change in which the stale pointer and the new group's base point at different channels. Only then does the restart to the group's base show up in which channel wins. The stimulus table first parks the pointer on channel 3 by granting a lone request. It then switches scheme with requests arranged so that the stale pointer and the reset pointer pick different winners. The same table mixes fixed-priority wins with rotation wins, so a pointer that moves on a fixed win shows up on the next rotation.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NumCh = 4;
  localparam int ChW   = $clog2(NumCh);
  localparam int ModeW = 2;

  typedef enum logic [ModeW-1:0] {
    ModeAllRr   = 2'b00,
    ModeTop1Rr  = 2'b01,
    ModeTop2Rr  = 2'b10,
    ModeFixed   = 2'b11
  } arbMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic evalEn;
    logic modeChanged;
  } arbCtrl_t;

  // lowest channel of the rotating group for a scheme
  function automatic logic [ChW-1:0] groupBase(arbMode_e m);
    case (m)
      ModeTop1Rr: groupBase = ChW'(1);
      ModeTop2Rr: groupBase = ChW'(2);
      default:    groupBase = '0;
    endcase
  endfunction
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 arbStrobe,
  input  logic [ModeW-1:0]     modeSel,
  output arbMode_e             curMode,
  output arbCtrl_t             ctrlStb
);
  arbMode_e lastMode;

  assign curMode = arbMode_e'(modeSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lastMode <= ModeAllRr;
    else if (arbStrobe) lastMode <= curMode;
  end

  always_comb begin
    ctrlStb.evalEn      = arbStrobe;
    ctrlStb.modeChanged = (curMode != lastMode);
  end
endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumCh-1:0]  reqVec,
  input  arbMode_e          curMode,
  input  arbCtrl_t          ctrlStb,
  output logic [NumCh-1:0]  grantOh,
  output logic              grantValid
);
  logic [ChW-1:0]   rrPtr, ptrUse, baseCh, nextPtr, rrIdx, cand;
  logic [NumCh-1:0] inRr, fixedHit, rrHit, winner;
  logic             fixedFound, rrFound, rrWin;

  assign baseCh = groupBase(curMode);
  assign ptrUse = ctrlStb.modeChanged ? baseCh : rrPtr;

  // membership of each channel in the rotating group
  for (genvar g = 0; g < NumCh; g++) begin : gMember
    assign inRr[g] = (curMode != ModeFixed) && (ChW'(g) >= baseCh);
  end

  // fixed part: lowest-index requesting channel outside the group
  always_comb begin
    fixedHit   = '0;
    fixedFound = 1'b0;
    for (int i = 0; i < NumCh; i++) begin
      if (!fixedFound && reqVec[i] && !inRr[i]) begin
        fixedHit[i] = 1'b1;
        fixedFound  = 1'b1;
      end
    end
  end

  // rotating part: search from the pointer, wrapping inside the group
  always_comb begin
    rrHit   = '0;
    rrFound = 1'b0;
    rrIdx   = '0;
    cand    = '0;
    for (int off = 0; off < NumCh; off++) begin
      cand = ptrUse + ChW'(off);
      if (!rrFound && reqVec[cand] && inRr[cand]) begin
        rrHit[cand] = 1'b1;
        rrIdx       = cand;
        rrFound     = 1'b1;
      end
    end
  end

  assign winner  = fixedFound ? fixedHit : rrHit;
  assign rrWin   = !fixedFound && rrFound;
  assign nextPtr = (rrIdx == ChW'(NumCh - 1)) ? baseCh : rrIdx + ChW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr      <= '0;
      grantOh    <= '0;
      grantValid <= 1'b0;
    end else if (ctrlStb.evalEn) begin
      grantOh    <= winner;
      grantValid <= |winner;
      if (rrWin)                    rrPtr <= nextPtr;
      else if (ctrlStb.modeChanged) rrPtr <= baseCh;
    end
  end

  // R10: grant never names two channels
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh));
  // R10: valid flag tracks a nonzero grant
  a_r10_valid: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grantOh != '0));
  // R10: only a requesting channel is granted
  a_r10_requested: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.evalEn |=> ((grantOh & ~$past(reqVec)) == '0));
  // R8: grant holds between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlStb.evalEn |=> ($stable(grantOh) && $stable(grantValid)));
  // R7: idle strobe gives no grant and keeps the pointer
  a_r7_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.evalEn && reqVec == '0 && !ctrlStb.modeChanged)
      |=> (!grantValid && $stable(rrPtr)));
  // R2: channel 0 wins in every scheme except full rotation
  a_r2_ch0_first: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.evalEn && curMode != ModeAllRr && reqVec[0])
      |=> (grantOh == NumCh'(1)));
endmodule

// File: rtl/dma_mix_arbiter.sv
module dma_mix_arbiter
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NumCh-1:0]  reqVec,
  input  logic [ModeW-1:0]  modeSel,
  input  logic              arbStrobe,
  output logic [NumCh-1:0]  grantOh,
  output logic              grantValid
);
  arbMode_e curMode;
  arbCtrl_t ctrlStb;

  dma_arb_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .arbStrobe (arbStrobe),
    .modeSel   (modeSel),
    .curMode   (curMode),
    .ctrlStb   (ctrlStb)
  );

  dma_arb_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .reqVec     (reqVec),
    .curMode    (curMode),
    .ctrlStb    (ctrlStb),
    .grantOh    (grantOh),
    .grantValid (grantValid)
  );
endmodule

// File: tb/tb_dma_mix_arbiter.sv
module tb_dma_mix_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqVec = '0;
  logic [1:0] modeSel = '0;
  logic       arbStrobe = 1'b0;
  logic [3:0] grantOh;
  logic       grantValid;
  int         nRun = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  dma_mix_arbiter dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .modeSel(modeSel),
    .arbStrobe(arbStrobe), .grantOh(grantOh), .grantValid(grantValid)
  );

  always #5 clk = ~clk;

  localparam int NVec = 25;
  // {mode, request, expected grant}
  localparam logic [9:0] VEC [NVec] = '{
    {2'b00, 4'b1111, 4'b0001},  // R5 first grant, R1
    {2'b00, 4'b1111, 4'b0010},
    {2'b00, 4'b1111, 4'b0100},
    {2'b00, 4'b1111, 4'b1000},
    {2'b00, 4'b1010, 4'b0010},  // ptr -> 2
    {2'b00, 4'b0000, 4'b0000},  // R7 pointer holds at 2
    {2'b00, 4'b0100, 4'b0100},  // ptr -> 3
    {2'b01, 4'b1110, 4'b0010},  // R9 restart at 1 (stale 3 would give ch3)
    {2'b01, 4'b1111, 4'b0001},  // R2 fixed win, R6 ptr stays 2
    {2'b01, 4'b1110, 4'b0100},
    {2'b01, 4'b1111, 4'b0001},  // R6 ptr stays 3
    {2'b01, 4'b1110, 4'b1000},  // wrap to 1
    {2'b01, 4'b1100, 4'b0100},  // ptr -> 3
    {2'b10, 4'b1100, 4'b0100},  // R9 restart at 2
    {2'b10, 4'b1110, 4'b0010},  // R3 ch1 above group
    {2'b10, 4'b1100, 4'b1000},
    {2'b10, 4'b1101, 4'b0001},
    {2'b10, 4'b1100, 4'b0100},
    {2'b11, 4'b1110, 4'b0010},  // R4
    {2'b11, 4'b1100, 4'b0100},
    {2'b11, 4'b1000, 4'b1000},
    {2'b11, 4'b1111, 4'b0001},
    {2'b00, 4'b0100, 4'b0100},
    {2'b00, 4'b1001, 4'b1000},
    {2'b00, 4'b1001, 4'b0001}
  };

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got valid/grant %b expected %b", tag, got, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] m, input logic [3:0] r);
    @(negedge clk);
    modeSel = m; reqVec = r; arbStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    arbStrobe = 1'b0;
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00: return "R1 R6 R9";
      2'b01: return "R2 R6 R9";
      2'b10: return "R3 R6 R9";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset", {grantValid, grantOh}, 5'b0_0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R5 idle after reset", {grantValid, grantOh}, 5'b0_0000);

    for (int i = 0; i < NVec; i++) begin
      strobe(VEC[i][9:8], VEC[i][7:4]);
      check(modeTag(VEC[i][9:8]), {grantValid, grantOh}, {|VEC[i][3:0], VEC[i][3:0]});
    end

    // R8: no strobe, inputs change, grant holds (last grant ch0)
    @(negedge clk);
    reqVec = 4'b1110; modeSel = 2'b11;
    repeat (3) @(negedge clk);
    check("R8 hold", {grantValid, grantOh}, 5'b1_0001);
    // R7: idle strobe clears grant
    strobe(2'b11, 4'b0000);
    check("R7 no request", {grantValid, grantOh}, 5'b0_0000);
    // R10: single request yields single grant
    strobe(2'b11, 4'b0100);
    check("R10 one-hot", {grantValid, grantOh}, 5'b1_0100);

    // R5: reset mid-run restores pointer and mode history
    rstN = 1'b0;
    @(negedge clk);
    check("R5 reset again", {grantValid, grantOh}, 5'b0_0000);
    rstN = 1'b1;
    strobe(2'b00, 4'b1111);
    check("R5 pointer at ch0", {grantValid, grantOh}, 5'b1_0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule